// File: doc/BRIEF.md
# Conditional Faulting Move Unit

This unit carries out one predicated move per cycle between register operands and a simple memory request port. A 4-bit condition code is tested against the current status flags. Two mode bits then pick one of four move forms. The forms cover a conditional load, a conditional store, a move into a separate new destination, and a zeroing move. A memory operand or a register operand can take the r/m role. When the predicate is false in a fault-suppressing form, the memory access is not issued at all, so the stub memory's fault indication cannot reach the fault output.

Memory requests are combinational from the operation inputs. The stub memory answers in the same cycle with read data and a fault flag. The register writeback and the fault report are registered and appear on the clock edge that follows the operation. Operand size shapes both the register result and the store data. A 16-bit result keeps the upper bits of the old destination. A 32-bit result clears the upper half, whatever the predicate.

Top module: `cfmove_unit`

## Requirements
- R1: The predicate is computed from flags {OF,SF,ZF,PF,CF} = flags[4:0] (bit 0 CF, bit 1 PF, bit 2 ZF, bit 3 SF, bit 4 OF). cc[3:1] chooses the base test: 0 OF, 1 CF, 2 ZF, 3 CF|ZF, 4 SF, 5 PF, 6 SF^OF, 7 ZF|(SF^OF). cc[0]=1 inverts the base test.
- R2: The form is {mode_nd,mode_nf}. Form 0 writes the reg operand (wb_target 0) from r/m. Form 1 with a register r/m writes the r/m register (wb_target 1) from reg_val. Forms 2 and 3 write the new destination (wb_target 2) from r/m. The r/m value is mem_rdata when rm_is_mem=1 and rm_val otherwise.
- R3: When the predicate is false, forms 0, 3 and register-r/m form 1 write zero to their target. Form 2 writes reg_val instead. Every form other than a memory form 1 writes back.
- R4: With rm_is_mem=1, forms 0 and 3 raise mem_rd_en only when the predicate is true. Form 2 raises mem_rd_en regardless of the predicate.
- R5: Form 1 with rm_is_mem=1 is a conditional store. It raises mem_wr_en only when the predicate is true and never writes back. mem_wdata carries reg_val shaped to the operand size with the bits above the size zero.
- R6: fault_out is set one cycle after an operation whose memory request was issued while mem_fault_in was 1, and at no other time. An operation that faults does not write back.
- R7: op_size 0 is 16-bit, 1 is 32-bit, and 2 or 3 is 64-bit. A 16-bit result keeps bits 63:16 of the target's old value (reg_val, rm_val or dst_old for targets 0, 1, 2). A 32-bit result has bits 63:32 zero.
- R8: wb_en, wb_target and wb_data update on the clock edge after op_valid. With op_valid low, no memory request is issued and wb_en is low on the next cycle.
- R9: After a synchronous active-low reset, wb_en, fault_out and wb_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| cc | input | 4 | Condition code |
| flags | input | 5 | Status flags {OF,SF,ZF,PF,CF} |
| op_size | input | 2 | Operand size code |
| rm_is_mem | input | 1 | r/m operand is memory |
| mode_nd | input | 1 | New-destination mode bit |
| mode_nf | input | 1 | No-flags / direction mode bit |
| reg_val | input | 64 | Value of the reg operand |
| rm_val | input | 64 | Value of the r/m register |
| dst_old | input | 64 | Old value of the new destination register |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data from the stub memory |
| mem_fault_in | input | 1 | Stub memory flags the current access as faulting |
| wb_en | output | 1 | Register writeback valid |
| wb_target | output | 2 | Writeback target: 0 reg, 1 r/m, 2 new destination |
| wb_data | output | 64 | Writeback value |
| fault_out | output | 1 | Reported memory fault |

## Verification
The first sweep runs all 16 condition codes against all 32 flag combinations through the zeroing register form. The written value is either the r/m value or zero, so every predicate outcome can be seen in it. A second sweep crosses the four forms with memory and register r/m, three sizes, true and false predicates, and a faulting or clean stub memory. This separates suppressed from issued accesses, store from load direction, the zeroing forms from the plain form, and the kept upper bits from the cleared ones. Extra cases cover an idle cycle with a pending true condition and the reset state.

// File: rtl/cfm_pkg.sv
// Shared types for the conditional faulting move unit.
// Assumes flags arrive as {OF,SF,ZF,PF,CF}.
package cfm_pkg;

    localparam int FLG_CF = 0;
    localparam int FLG_PF = 1;
    localparam int FLG_ZF = 2;
    localparam int FLG_SF = 3;
    localparam int FLG_OF = 4;
    localparam int FLAG_W = 5;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_64B = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_RM  = 2'd1,
        TGT_NEW = 2'd2,
        TGT_NA  = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        SRC_RM   = 2'd0,
        SRC_REG  = 2'd1,
        SRC_ZERO = 2'd2,
        SRC_NA   = 2'd3
    } src_e;

endpackage

// File: rtl/cfm_cond.sv
// Condition evaluator: tests a 4-bit code against the status flags.
// Assumes the usual pairing where the low code bit inverts the test.
module cfm_cond
    import cfm_pkg::*;
(
    input  logic [3:0]        cc,
    input  logic [FLAG_W-1:0] flags,
    output logic              pred
);

    logic base;
    logic sf_ne_of;

    // Select the base test from the upper code bits, then apply inversion.
    always_comb begin
        sf_ne_of = flags[FLG_SF] ^ flags[FLG_OF];
        case (cc[3:1])
            3'd0: base = flags[FLG_OF];
            3'd1: base = flags[FLG_CF];
            3'd2: base = flags[FLG_ZF];
            3'd3: base = flags[FLG_CF] | flags[FLG_ZF];
            3'd4: base = flags[FLG_SF];
            3'd5: base = flags[FLG_PF];
            3'd6: base = sf_ne_of;
            3'd7: base = flags[FLG_ZF] | sf_ne_of;
            default: base = 1'b0;
        endcase
        pred = base ^ cc[0];
    end

endmodule

// File: rtl/cfm_route.sv
// Form decoder: from the mode bits, operand kind and predicate, decides
// which memory request is issued, whether a writeback happens, where it
// goes and which value feeds it. Assumes one operation per cycle.
module cfm_route
    import cfm_pkg::*;
(
    input  logic    op_valid,
    input  logic    mode_nd,
    input  logic    mode_nf,
    input  logic    rm_is_mem,
    input  logic    pred,
    output logic    rd_en,
    output logic    wr_en,
    output logic    wb_req,
    output target_e tgt,
    output src_e    src
);

    logic [1:0] form;
    logic       is_store;

    // Decode the form into target, value source and request enables.
    always_comb begin
        form     = {mode_nd, mode_nf};
        is_store = (form == 2'd1) && rm_is_mem;
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        tgt      = TGT_REG;
        src      = SRC_ZERO;
        case (form)
            2'd0: begin
                tgt   = TGT_REG;
                src   = pred ? SRC_RM : SRC_ZERO;
                rd_en = op_valid && rm_is_mem && pred;
            end
            2'd1: begin
                tgt   = TGT_RM;
                src   = pred ? SRC_REG : SRC_ZERO;
                wr_en = op_valid && rm_is_mem && pred;
            end
            2'd2: begin
                tgt   = TGT_NEW;
                src   = pred ? SRC_RM : SRC_REG;
                rd_en = op_valid && rm_is_mem;
            end
            default: begin
                tgt   = TGT_NEW;
                src   = pred ? SRC_RM : SRC_ZERO;
                rd_en = op_valid && rm_is_mem && pred;
            end
        endcase
        wb_req = op_valid && !is_store;
    end

endmodule

// File: rtl/cfm_shape.sv
// Size shaper: fits a value to the operand size. A 16-bit value keeps
// the supplied old upper bits; 32-bit clears the upper half.
// Assumes DATA_W is a multiple of 4 so the size fractions are whole.
module cfm_shape
    import cfm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  opsize_e                  size,
    input  logic [DATA_W-1:0]        value,
    input  logic [DATA_W-DATA_W/4-1:0] old_hi,
    output logic [DATA_W-1:0]        shaped
);

    localparam int W16 = DATA_W / 4;
    localparam int W32 = DATA_W / 2;

    // Merge the value with the old or cleared upper bits for the size.
    always_comb begin
        case (size)
            SZ_16:   shaped = {old_hi, value[W16-1:0]};
            SZ_32:   shaped = {{(DATA_W-W32){1'b0}}, value[W32-1:0]};
            default: shaped = value;
        endcase
    end

endmodule

// File: rtl/cfmove_unit.sv
// Conditional faulting move unit (top). Issues memory requests in the
// same cycle as the operation, then registers the writeback and fault.
// Assumes the stub memory answers read data and fault combinationally.
module cfmove_unit
    import cfm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        cc,
    input  logic [4:0]        flags,
    input  logic [1:0]        op_size,
    input  logic              rm_is_mem,
    input  logic              mode_nd,
    input  logic              mode_nf,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] dst_old,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_fault_in,
    output logic              wb_en,
    output logic [1:0]        wb_target,
    output logic [DATA_W-1:0] wb_data,
    output logic              fault_out
);

    localparam int HI_W = DATA_W - DATA_W / 4;

    logic              pred;
    logic              wb_req;
    target_e           tgt;
    src_e              src;
    opsize_e           size;
    logic              access;
    logic              hit_fault;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] result;

    assign size = opsize_e'(op_size);

    cfm_cond u_cond (
        .cc    (cc),
        .flags (flags),
        .pred  (pred)
    );

    cfm_route u_route (
        .op_valid  (op_valid),
        .mode_nd   (mode_nd),
        .mode_nf   (mode_nf),
        .rm_is_mem (rm_is_mem),
        .pred      (pred),
        .rd_en     (mem_rd_en),
        .wr_en     (mem_wr_en),
        .wb_req    (wb_req),
        .tgt       (tgt),
        .src       (src)
    );

    // Pick the source value and the old value of the chosen target.
    always_comb begin
        case (src)
            SRC_RM:  src_val = rm_is_mem ? mem_rdata : rm_val;
            SRC_REG: src_val = reg_val;
            default: src_val = '0;
        endcase
        case (tgt)
            TGT_RM:  old_val = rm_val;
            TGT_NEW: old_val = dst_old;
            default: old_val = reg_val;
        endcase
    end

    cfm_shape #(.DATA_W(DATA_W)) u_shape_wb (
        .size   (size),
        .value  (src_val),
        .old_hi (old_val[DATA_W-1:DATA_W-HI_W]),
        .shaped (result)
    );

    cfm_shape #(.DATA_W(DATA_W)) u_shape_st (
        .size   (size),
        .value  (reg_val),
        .old_hi ({HI_W{1'b0}}),
        .shaped (mem_wdata)
    );

    assign mem_size  = op_size;
    assign access    = mem_rd_en || mem_wr_en;
    assign hit_fault = access && mem_fault_in;

    // Register the writeback and the fault report for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en     <= 1'b0;
            wb_target <= 2'd0;
            wb_data   <= '0;
            fault_out <= 1'b0;
        end else begin
            wb_en     <= wb_req && !hit_fault;
            wb_target <= tgt;
            wb_data   <= result;
            fault_out <= hit_fault;
        end
    end

    // R4
    sup_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !pred && rm_is_mem && !(mode_nd && !mode_nf))
        |-> (!mem_rd_en && !mem_wr_en));

    // R6
    fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_out |-> $past(mem_rd_en || mem_wr_en));

    // R6
    fault_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_out |-> !wb_en);

    // R8
    wb_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(op_valid));

    // R5
    store_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !wb_en);

    // R7
    clr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && $past(op_size) == 2'd1) |-> (wb_data[DATA_W-1:DATA_W/2] == '0));

endmodule

// File: tb/cfmove_unit_test.sv
module cfmove_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  cc;
    logic [4:0]  flags;
    logic [1:0]  op_size;
    logic        rm_is_mem, mode_nd, mode_nf;
    logic [63:0] reg_val, rm_val, dst_old, mem_rdata;
    logic        mem_fault_in;
    logic        mem_rd_en, mem_wr_en, wb_en, fault_out;
    logic [1:0]  mem_size, wb_target;
    logic [63:0] mem_wdata, wb_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [63:0] REGV = 64'h1111_2222_3333_4444;
    localparam logic [63:0] RMV  = 64'h5555_6666_7777_8888;
    localparam logic [63:0] OLDV = 64'h9999_AAAA_BBBB_CCCC;
    localparam logic [63:0] MEMV = 64'hDDDD_EEEE_FFFF_0123;

    always #2 clk = ~clk;

    cfmove_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cc(cc), .flags(flags),
        .op_size(op_size), .rm_is_mem(rm_is_mem), .mode_nd(mode_nd),
        .mode_nf(mode_nf), .reg_val(reg_val), .rm_val(rm_val), .dst_old(dst_old),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_fault_in(mem_fault_in),
        .wb_en(wb_en), .wb_target(wb_target), .wb_data(wb_data), .fault_out(fault_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Predicate from the code table and flag order of R1.
    function automatic bit exp_pred(input logic [3:0] c, input logic [4:0] f);
        bit cf = f[0], pf = f[1], zf = f[2], sf = f[3], of = f[4];
        bit b;
        case (c[3:1])
            3'd0: b = of;
            3'd1: b = cf;
            3'd2: b = zf;
            3'd3: b = cf | zf;
            3'd4: b = sf;
            3'd5: b = pf;
            3'd6: b = sf ^ of;
            default: b = zf | (sf ^ of);
        endcase
        return b ^ c[0];
    endfunction

    function automatic logic [63:0] fit(input int s, input logic [63:0] v, input logic [63:0] o);
        if (s == 0) return {o[63:16], v[15:0]};
        if (s == 1) return {32'h0, v[31:0]};
        return v;
    endfunction

    task automatic drive(input int f, input bit m, input int s, input logic [3:0] c,
                         input logic [4:0] fl, input bit fi, input bit v);
        op_valid = v; mode_nd = f[1]; mode_nf = f[0]; rm_is_mem = m;
        op_size = s[1:0]; cc = c; flags = fl; mem_fault_in = fi;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        reg_val = REGV; rm_val = RMV; dst_old = OLDV; mem_rdata = MEMV;
        rst_n = 1'b0;
        drive(0, 0, 2, 4'h0, 5'h0, 0, 0);
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 wb_en", {63'h0, wb_en}, 64'h0);
        chk("R9 fault_out", {63'h0, fault_out}, 64'h0);
        chk("R9 wb_data", wb_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3: every code against every flag pattern, zeroing register form
        for (int c = 0; c < 16; c++) begin
            for (int fl = 0; fl < 32; fl++) begin
                drive(0, 0, 2, c[3:0], fl[4:0], 0, 1);
                @(negedge clk);
                chk("R1 predicate via wb_data", wb_data,
                    exp_pred(c[3:0], fl[4:0]) ? RMV : 64'h0);
            end
        end

        // R2-R7: forms x r/m kind x size x predicate x fault
        for (int f = 0; f < 4; f++)
        for (int m = 0; m < 2; m++)
        for (int s = 0; s < 3; s++)
        for (int p = 0; p < 2; p++)
        for (int fi = 0; fi < 2; fi++) begin
            bit erd, ewr, eflt, ewb;
            int et;
            logic [63:0] sv, ov;
            erd  = (m == 1) && (f == 2 || ((f == 0 || f == 3) && p == 1));
            ewr  = (m == 1) && f == 1 && p == 1;
            eflt = (erd || ewr) && fi == 1;
            ewb  = !(f == 1 && m == 1) && !eflt;
            et   = (f == 0) ? 0 : (f == 1) ? 1 : 2;
            if (p == 1) sv = (f == 1) ? REGV : ((m == 1) ? MEMV : RMV);
            else        sv = (f == 2) ? REGV : 64'h0;
            ov = (et == 0) ? REGV : (et == 1) ? RMV : OLDV;
            // cc 4 tests ZF (R1); ZF is flags bit 2
            drive(f, m[0], s, 4'h4, p[0] ? 5'h04 : 5'h00, fi[0], 1);
            #1;
            chk("R4 mem_rd_en", {63'h0, mem_rd_en}, {63'h0, erd});
            chk("R5 mem_wr_en", {63'h0, mem_wr_en}, {63'h0, ewr});
            if (ewr) chk("R5 mem_wdata", mem_wdata, fit(s, REGV, 64'h0));
            @(negedge clk);
            chk("R6 fault_out", {63'h0, fault_out}, {63'h0, eflt});
            chk("R3 wb_en", {63'h0, wb_en}, {63'h0, ewb});
            if (ewb) begin
                chk("R2 wb_target", {62'h0, wb_target}, et);
                chk("R7 wb_data", wb_data, fit(s, sv, ov));
            end
        end

        // R8: idle cycle with a true load condition pending
        drive(0, 1, 2, 4'h4, 5'h04, 1, 0);
        #1;
        chk("R8 idle rd", {63'h0, mem_rd_en}, 64'h0);
        chk("R8 idle wr", {63'h0, mem_wr_en}, 64'h0);
        @(negedge clk);
        chk("R8 idle wb_en", {63'h0, wb_en}, 64'h0);
        chk("R8 idle fault", {63'h0, fault_out}, 64'h0);

        // R7: reserved size code 3 behaves as 64-bit
        drive(3, 0, 3, 4'h4, 5'h04, 0, 1);
        @(negedge clk);
        chk("R7 size 3 wb_data", wb_data, RMV);
        op_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule